// File: doc/BRIEF.md
# Branch Resolution Unit

This block takes one decoded jump-class instruction per cycle and decides where the program goes next. It gets the four-bit operation code, a bit that selects the 32-bit comparison class, a bit that picks the second operand, the two register values, the 32-bit immediate, the signed 16-bit displacement and the byte address of the current instruction. One cycle later it presents a taken flag and the next instruction address. It also raises a one-cycle indication for a helper call or a program exit, or flags the instruction as illegal.

The comparison set mixes unsigned and signed relations with equality, inequality and a bit-test. Every instruction is eight bytes long, so a taken branch moves by a whole number of instruction slots relative to the slot after the current one. Helper dispatch and stack handling stay outside: the unit only reports a call's immediate and register index, and it reports an exit.

Top module: `bru_resolve`

## Requirements
- R1: Operation codes 2 (greater), 3 (greater-or-equal), 10 (less) and 11 (less-or-equal) compare the first operand with the second as unsigned numbers.
- R2: Operation codes 6 (greater), 7 (greater-or-equal), 12 (less) and 13 (less-or-equal) compare as two's-complement signed numbers.
- R3: Code 1 is taken on equality, code 5 on inequality, and code 4 when the bitwise AND of the two operands is nonzero.
- R4: With the operand-select bit at 0 the second operand is the immediate, sign-extended to 64 bits. With the bit at 1 it is the source register value. The first operand is always the destination register value.
- R5: With the class bit at 1 (32-bit class) only bits 31:0 of both operands take part, and bit 31 is the sign for signed codes. With the class bit at 0 all 64 bits are compared.
- R6: A taken branch gives next address = current address + (displacement + 1) × 8. The displacement is signed and the sum wraps modulo 2^64.
- R7: A conditional branch that is not taken gives next address = current address + 8.
- R8: Code 0 in the 64-bit class is always taken and uses the R6 target.
- R9: Code 8 in the 64-bit class raises the call strobe for one result cycle. It carries the immediate and the 4-bit source register index, gives next address = current + 8, and leaves the taken flag low.
- R10: Code 9 in the 64-bit class raises the exit strobe. The next address equals the current address and the taken flag stays low.
- R11: Codes 14 and 15, and codes 0, 8 or 9 with the class bit at 1, raise the illegal flag. They give no taken flag and no strobe, and the next address equals the current address.
- R12: An instruction presented with the input valid high produces its result, with output valid high, on the next clock edge. A cycle without input valid produces output valid, taken, call, exit and illegal all low.
- R13: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | An instruction is presented this cycle |
| in_op_i | input | 4 | Operation code |
| in_narrow_i | input | 1 | 1 selects the 32-bit comparison class |
| in_use_reg_i | input | 1 | 1 selects the source register as the second operand, 0 the immediate |
| in_dst_i | input | 64 | Destination register value (first operand) |
| in_src_i | input | 64 | Source register value |
| in_src_idx_i | input | 4 | Source register index, forwarded on a call |
| in_imm_i | input | 32 | Immediate |
| in_disp_i | input | 16 | Signed displacement, in instructions |
| in_pc_i | input | 64 | Byte address of the current instruction |
| out_valid_o | output | 1 | Result valid |
| out_taken_o | output | 1 | Branch taken |
| out_next_pc_o | output | 64 | Next instruction address |
| out_call_o | output | 1 | Helper call strobe |
| out_call_imm_o | output | 32 | Immediate of the call |
| out_call_src_o | output | 4 | Source register index of the call |
| out_exit_o | output | 1 | Program exit strobe |
| out_illegal_o | output | 1 | Illegal jump-class instruction |

## Verification
On every cycle the assertions check the one-cycle result latency and the quiet outputs of an idle cycle. They also check that at most one of taken, call, exit and illegal is set, that fall-through, call and illegal addresses follow the current address, and that out-of-range codes are flagged. The direction of each compare cannot be seen from these properties. Only the bench's scenarios show it: unsigned against signed orderings at the 64-bit and 32-bit sign boundaries, immediate sign extension, the bit-test, and the extreme positive and negative displacements including wrap-around.

// File: rtl/bru_pkg.sv
`timescale 1ns/1ps
package bru_pkg;

    typedef enum logic [3:0] {
        BR_ALWAYS = 4'h0,
        BR_EQ     = 4'h1,
        BR_GTU    = 4'h2,
        BR_GEU    = 4'h3,
        BR_TEST   = 4'h4,
        BR_NE     = 4'h5,
        BR_GTS    = 4'h6,
        BR_GES    = 4'h7,
        BR_CALL   = 4'h8,
        BR_EXIT   = 4'h9,
        BR_LTU    = 4'hA,
        BR_LEU    = 4'hB,
        BR_LTS    = 4'hC,
        BR_LES    = 4'hD
    } br_op_e;

    localparam logic [3:0] BR_LAST_CODE = 4'hD;

    function automatic logic br_code_defined(input logic [3:0] op);
        return op <= BR_LAST_CODE;
    endfunction

    function automatic logic br_wide_only(input logic [3:0] op);
        return (op == BR_ALWAYS) || (op == BR_CALL) || (op == BR_EXIT);
    endfunction

endpackage

// File: rtl/bru_operand.sv
`timescale 1ns/1ps
module bru_operand #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 32
) (
    input  logic             use_reg_i,
    input  logic [XLEN-1:0]  src_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [XLEN-1:0]  rhs_o
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        end else begin : g_noext
            assign imm_ext = imm_i[XLEN-1:0];
        end
    endgenerate

    always_comb begin
        rhs_o = use_reg_i ? src_i : imm_ext;
    end
endmodule

// File: rtl/bru_cond.sv
`timescale 1ns/1ps
module bru_cond
    import bru_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int HALF_W = 32
) (
    input  logic [3:0]      op_i,
    input  logic            narrow_i,
    input  logic [XLEN-1:0] lhs_i,
    input  logic [XLEN-1:0] rhs_i,
    output logic            hit_o
);
    localparam int NUM_W = 2;

    logic [NUM_W-1:0] eq_w;
    logic [NUM_W-1:0] ltu_w;
    logic [NUM_W-1:0] lts_w;
    logic [NUM_W-1:0] any_w;

    for (genvar g = 0; g < NUM_W; g++) begin : g_width
        localparam int W = (g == 0) ? XLEN : HALF_W;
        logic [W-1:0] a_w;
        logic [W-1:0] b_w;
        assign a_w      = lhs_i[W-1:0];
        assign b_w      = rhs_i[W-1:0];
        assign eq_w[g]  = (a_w == b_w);
        assign ltu_w[g] = (a_w < b_w);
        assign lts_w[g] = ($signed(a_w) < $signed(b_w));
        assign any_w[g] = |(a_w & b_w);
    end

    logic sel;
    logic eq;
    logic ltu;
    logic lts;
    logic any;

    always_comb begin
        sel = narrow_i;
        eq  = eq_w[sel];
        ltu = ltu_w[sel];
        lts = lts_w[sel];
        any = any_w[sel];
        unique case (op_i)
            BR_ALWAYS: hit_o = 1'b1;
            BR_EQ:     hit_o = eq;
            BR_NE:     hit_o = !eq;
            BR_TEST:   hit_o = any;
            BR_GTU:    hit_o = !ltu && !eq;
            BR_GEU:    hit_o = !ltu;
            BR_LTU:    hit_o = ltu;
            BR_LEU:    hit_o = ltu || eq;
            BR_GTS:    hit_o = !lts && !eq;
            BR_GES:    hit_o = !lts;
            BR_LTS:    hit_o = lts;
            BR_LES:    hit_o = lts || eq;
            default:   hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bru_target.sv
`timescale 1ns/1ps
module bru_target #(
    parameter int XLEN       = 64,
    parameter int DISP_W     = 16,
    parameter int INSN_BYTES = 8
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [XLEN-1:0]   jump_o,
    output logic [XLEN-1:0]   seq_o
);
    localparam int SHIFT = $clog2(INSN_BYTES);
    localparam int EXT_W = XLEN - DISP_W;

    logic [XLEN-1:0] disp_ext;
    logic [XLEN-1:0] slots;

    always_comb begin
        disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
        slots    = disp_ext + XLEN'(1);
        jump_o   = pc_i + (slots << SHIFT);
        seq_o    = pc_i + XLEN'(INSN_BYTES);
    end
endmodule

// File: rtl/bru_resolve.sv
`timescale 1ns/1ps
module bru_resolve
    import bru_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int HALF_W     = 32,
    parameter int IMM_W      = 32,
    parameter int DISP_W     = 16,
    parameter int REG_IDX_W  = 4,
    parameter int INSN_BYTES = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 in_valid_i,
    input  logic [3:0]           in_op_i,
    input  logic                 in_narrow_i,
    input  logic                 in_use_reg_i,
    input  logic [XLEN-1:0]      in_dst_i,
    input  logic [XLEN-1:0]      in_src_i,
    input  logic [REG_IDX_W-1:0] in_src_idx_i,
    input  logic [IMM_W-1:0]     in_imm_i,
    input  logic [DISP_W-1:0]    in_disp_i,
    input  logic [XLEN-1:0]      in_pc_i,
    output logic                 out_valid_o,
    output logic                 out_taken_o,
    output logic [XLEN-1:0]      out_next_pc_o,
    output logic                 out_call_o,
    output logic [IMM_W-1:0]     out_call_imm_o,
    output logic [REG_IDX_W-1:0] out_call_src_o,
    output logic                 out_exit_o,
    output logic                 out_illegal_o
);

    typedef struct packed {
        logic                 valid;
        logic                 taken;
        logic [XLEN-1:0]      next_pc;
        logic                 call;
        logic [IMM_W-1:0]     call_imm;
        logic [REG_IDX_W-1:0] call_src;
        logic                 leave;
        logic                 illegal;
    } res_t;

    logic [XLEN-1:0] rhs;
    logic            hit;
    logic [XLEN-1:0] jump_pc;
    logic [XLEN-1:0] seq_pc;
    logic            bad_code;

    bru_operand #(
        .XLEN  (XLEN),
        .IMM_W (IMM_W)
    ) u_operand (
        .use_reg_i (in_use_reg_i),
        .src_i     (in_src_i),
        .imm_i     (in_imm_i),
        .rhs_o     (rhs)
    );

    bru_cond #(
        .XLEN   (XLEN),
        .HALF_W (HALF_W)
    ) u_cond (
        .op_i     (in_op_i),
        .narrow_i (in_narrow_i),
        .lhs_i    (in_dst_i),
        .rhs_i    (rhs),
        .hit_o    (hit)
    );

    bru_target #(
        .XLEN       (XLEN),
        .DISP_W     (DISP_W),
        .INSN_BYTES (INSN_BYTES)
    ) u_target (
        .pc_i   (in_pc_i),
        .disp_i (in_disp_i),
        .jump_o (jump_pc),
        .seq_o  (seq_pc)
    );

    res_t st_d;
    res_t st_q;

    always_comb begin
        bad_code = !br_code_defined(in_op_i) ||
                   (in_narrow_i && br_wide_only(in_op_i));
        st_d     = '0;
        if (in_valid_i) begin
            st_d.valid = 1'b1;
            if (bad_code) begin
                st_d.illegal = 1'b1;
                st_d.next_pc = in_pc_i;
            end else if (in_op_i == BR_CALL) begin
                st_d.call     = 1'b1;
                st_d.call_imm = in_imm_i;
                st_d.call_src = in_src_idx_i;
                st_d.next_pc  = seq_pc;
            end else if (in_op_i == BR_EXIT) begin
                st_d.leave   = 1'b1;
                st_d.next_pc = in_pc_i;
            end else begin
                st_d.taken   = hit;
                st_d.next_pc = hit ? jump_pc : seq_pc;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o    = st_q.valid;
    assign out_taken_o    = st_q.taken;
    assign out_next_pc_o  = st_q.next_pc;
    assign out_call_o     = st_q.call;
    assign out_call_imm_o = st_q.call_imm;
    assign out_call_src_o = st_q.call_src;
    assign out_exit_o     = st_q.leave;
    assign out_illegal_o  = st_q.illegal;

endmodule

// File: rtl/bru_resolve_chk.sv
`timescale 1ns/1ps
module bru_resolve_chk #(
    parameter int XLEN       = 64,
    parameter int IMM_W      = 32,
    parameter int INSN_BYTES = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             in_valid_i,
    input logic [3:0]       in_op_i,
    input logic             in_narrow_i,
    input logic [IMM_W-1:0] in_imm_i,
    input logic [XLEN-1:0]  in_pc_i,
    input logic             out_valid_o,
    input logic             out_taken_o,
    input logic [XLEN-1:0]  out_next_pc_o,
    input logic             out_call_o,
    input logic [IMM_W-1:0] out_call_imm_o,
    input logic             out_exit_o,
    input logic             out_illegal_o
);

    p_valid_follow_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o);

    p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !out_valid_o |-> !(out_taken_o || out_call_o || out_exit_o || out_illegal_o));

    p_single_outcome_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> $onehot0({out_taken_o, out_call_o, out_exit_o, out_illegal_o}));

    p_exit_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && out_exit_o) |-> (out_next_pc_o == $past(in_pc_i)));

    p_illegal_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && out_illegal_o) |-> (out_next_pc_o == $past(in_pc_i)));

    p_fallthrough_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_taken_o && !out_exit_o && !out_illegal_o)
        |-> (out_next_pc_o == $past(in_pc_i) + XLEN'(INSN_BYTES)));

    p_bad_code_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && (in_op_i >= 4'hE)) |=> out_illegal_o);

    p_always_taken_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && (in_op_i == 4'h0) && !in_narrow_i) |=> out_taken_o);

    p_call_fields_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && (in_op_i == 4'h8) && !in_narrow_i)
        |=> (out_call_o && (out_call_imm_o == $past(in_imm_i))));

endmodule

bind bru_resolve bru_resolve_chk #(
    .XLEN       (XLEN),
    .IMM_W      (IMM_W),
    .INSN_BYTES (INSN_BYTES)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .in_valid_i     (in_valid_i),
    .in_op_i        (in_op_i),
    .in_narrow_i    (in_narrow_i),
    .in_imm_i       (in_imm_i),
    .in_pc_i        (in_pc_i),
    .out_valid_o    (out_valid_o),
    .out_taken_o    (out_taken_o),
    .out_next_pc_o  (out_next_pc_o),
    .out_call_o     (out_call_o),
    .out_call_imm_o (out_call_imm_o),
    .out_exit_o     (out_exit_o),
    .out_illegal_o  (out_illegal_o)
);

// File: tb/bru_resolve_tb_top.sv
`timescale 1ns/1ps
module bru_resolve_tb_top;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [3:0]  in_op_i = '0;
    logic        in_narrow_i = 1'b0;
    logic        in_use_reg_i = 1'b0;
    logic [63:0] in_dst_i = '0;
    logic [63:0] in_src_i = '0;
    logic [3:0]  in_src_idx_i = '0;
    logic [31:0] in_imm_i = '0;
    logic [15:0] in_disp_i = '0;
    logic [63:0] in_pc_i = '0;
    logic        out_valid_o;
    logic        out_taken_o;
    logic [63:0] out_next_pc_o;
    logic        out_call_o;
    logic [31:0] out_call_imm_o;
    logic [3:0]  out_call_src_o;
    logic        out_exit_o;
    logic        out_illegal_o;

    always #2 clk = ~clk;

    bru_resolve dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_ni),
        .in_valid_i     (in_valid_i),
        .in_op_i        (in_op_i),
        .in_narrow_i    (in_narrow_i),
        .in_use_reg_i   (in_use_reg_i),
        .in_dst_i       (in_dst_i),
        .in_src_i       (in_src_i),
        .in_src_idx_i   (in_src_idx_i),
        .in_imm_i       (in_imm_i),
        .in_disp_i      (in_disp_i),
        .in_pc_i        (in_pc_i),
        .out_valid_o    (out_valid_o),
        .out_taken_o    (out_taken_o),
        .out_next_pc_o  (out_next_pc_o),
        .out_call_o     (out_call_o),
        .out_call_imm_o (out_call_imm_o),
        .out_call_src_o (out_call_src_o),
        .out_exit_o     (out_exit_o),
        .out_illegal_o  (out_illegal_o)
    );

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        bit        v;
        bit        tk;
        bit [63:0] pc;
        bit        call;
        bit [31:0] cimm;
        bit [3:0]  csrc;
        bit        ex;
        bit        ill;
        string     tag;
    } exp_t;

    exp_t pend;
    bit   have_pend = 0;

    // Behavioural reference model written from the requirements.
    function automatic exp_t model(bit v, bit [3:0] op, bit nar, bit ur,
                                   bit [63:0] dst, bit [63:0] src, bit [3:0] sidx,
                                   bit [31:0] imm, bit [15:0] disp, bit [63:0] pc);
        exp_t e;
        bit [63:0] rhs;
        longint unsigned ua, ub;
        longint sa, sb;
        bit c;
        string base;
        e.v = 0; e.tk = 0; e.pc = 0; e.call = 0; e.cimm = 0; e.csrc = 0;
        e.ex = 0; e.ill = 0; e.tag = "R12";
        if (!v) return e;
        e.v = 1;
        rhs = ur ? src : {{32{imm[31]}}, imm};
        if (nar) begin
            ua = {32'b0, dst[31:0]};
            ub = {32'b0, rhs[31:0]};
            sa = longint'(int'(dst[31:0]));
            sb = longint'(int'(rhs[31:0]));
        end else begin
            ua = dst;
            ub = rhs;
            sa = longint'(dst);
            sb = longint'(rhs);
        end
        if (op >= 4'hE || (nar && (op == 4'h0 || op == 4'h8 || op == 4'h9))) begin
            e.ill = 1; e.pc = pc; e.tag = "R11";
            return e;
        end
        if (op == 4'h8) begin
            e.call = 1; e.cimm = imm; e.csrc = sidx; e.pc = pc + 64'd8; e.tag = "R9";
            return e;
        end
        if (op == 4'h9) begin
            e.ex = 1; e.pc = pc; e.tag = "R10";
            return e;
        end
        case (op)
            4'h0: begin c = 1;             base = "R8"; end
            4'h1: begin c = (ua == ub);    base = "R3"; end
            4'h5: begin c = (ua != ub);    base = "R3"; end
            4'h4: begin c = ((ua & ub) != 0); base = "R3"; end
            4'h2: begin c = (ua > ub);     base = "R1"; end
            4'h3: begin c = (ua >= ub);    base = "R1"; end
            4'hA: begin c = (ua < ub);     base = "R1"; end
            4'hB: begin c = (ua <= ub);    base = "R1"; end
            4'h6: begin c = (sa > sb);     base = "R2"; end
            4'h7: begin c = (sa >= sb);    base = "R2"; end
            4'hC: begin c = (sa < sb);     base = "R2"; end
            default: begin c = (sa <= sb); base = "R2"; end
        endcase
        e.tk = c;
        if (c) e.pc = pc + 64'((longint'(shortint'(disp)) + 1) * 8);
        else   e.pc = pc + 64'd8;
        e.tag = {base, c ? " R6" : " R7", nar ? " R5" : "", ur ? "" : " R4"};
        return e;
    endfunction

    task automatic check_pending();
        bit bad;
        if (!have_pend) return;
        n_checks++;
        bad = (out_valid_o != pend.v) || (out_taken_o != pend.tk) ||
              (out_call_o != pend.call) || (out_exit_o != pend.ex) ||
              (out_illegal_o != pend.ill);
        if (pend.v && out_next_pc_o != pend.pc) bad = 1;
        if (pend.call && (out_call_imm_o != pend.cimm || out_call_src_o != pend.csrc)) bad = 1;
        if (bad) begin
            n_fails++;
            $display("FAIL %s: actual v%0b t%0b pc=%h c%0b(%h,%0d) e%0b i%0b expected v%0b t%0b pc=%h c%0b(%h,%0d) e%0b i%0b",
                     pend.tag, out_valid_o, out_taken_o, out_next_pc_o, out_call_o,
                     out_call_imm_o, out_call_src_o, out_exit_o, out_illegal_o,
                     pend.v, pend.tk, pend.pc, pend.call, pend.cimm, pend.csrc,
                     pend.ex, pend.ill);
        end
    endtask

    task automatic apply(bit v, bit [3:0] op, bit nar, bit ur, bit [63:0] dst,
                         bit [63:0] src, bit [3:0] sidx, bit [31:0] imm,
                         bit [15:0] disp, bit [63:0] pc);
        @(negedge clk);
        check_pending();
        in_valid_i   = v;
        in_op_i      = op;
        in_narrow_i  = nar;
        in_use_reg_i = ur;
        in_dst_i     = dst;
        in_src_i     = src;
        in_src_idx_i = sidx;
        in_imm_i     = imm;
        in_disp_i    = disp;
        in_pc_i      = pc;
        pend         = model(v, op, nar, ur, dst, src, sidx, imm, disp, pc);
        have_pend    = 1;
    endtask

    function automatic bit [63:0] pick_val();
        case ($urandom_range(0, 7))
            0: return 64'd0;
            1: return 64'd1;
            2: return '1;
            3: return 64'h0000_0000_8000_0000;
            4: return 64'h8000_0000_0000_0000;
            5: return 64'h7FFF_FFFF_FFFF_FFFF;
            6: return {32'h0, $urandom()};
            default: return {$urandom(), $urandom()};
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_fails++;
        $display("FAIL R12: watchdog expired, actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R13: outputs zero during reset, even with an instruction presented
        repeat (2) @(negedge clk);
        in_valid_i = 1'b1;
        in_op_i    = 4'h0;
        @(negedge clk);
        n_checks++;
        if ({out_valid_o, out_taken_o, out_next_pc_o, out_call_o, out_call_imm_o,
             out_call_src_o, out_exit_o, out_illegal_o} != '0) begin
            n_fails++;
            $display("FAIL R13: actual v%0b t%0b pc=%h c%0b e%0b i%0b expected all zero",
                     out_valid_o, out_taken_o, out_next_pc_o, out_call_o, out_exit_o, out_illegal_o);
        end
        in_valid_i = 1'b0;
        @(negedge clk);
        rst_ni = 1'b1;

        // R8 / R6: displacement extremes and wrap
        apply(1, 4'h0, 0, 0, 0, 0, 0, 0, 16'h0000, 64'h1000);
        apply(1, 4'h0, 0, 0, 0, 0, 0, 0, 16'hFFFF, 64'h1000);
        apply(1, 4'h0, 0, 0, 0, 0, 0, 0, 16'h7FFF, 64'h1000);
        apply(1, 4'h0, 0, 0, 0, 0, 0, 0, 16'h8000, 64'h1000);
        apply(1, 4'h0, 0, 0, 0, 0, 0, 0, 16'h0003, 64'hFFFF_FFFF_FFFF_FFF8);
        // R1 versus R2 on the 64-bit sign boundary
        apply(1, 4'h2, 0, 1, '1, 64'd1, 0, 0, 16'd4, 64'h2000);
        apply(1, 4'h6, 0, 1, '1, 64'd1, 0, 0, 16'd4, 64'h2000);
        apply(1, 4'hC, 0, 1, 64'h8000_0000_0000_0000, 64'd0, 0, 0, 16'd2, 64'h2000);
        apply(1, 4'hA, 0, 1, 64'h8000_0000_0000_0000, 64'd0, 0, 0, 16'd2, 64'h2000);
        // R4: immediate sign extension
        apply(1, 4'hA, 0, 0, 64'd5, 64'd0, 0, 32'hFFFF_FFFF, 16'd1, 64'h3000);
        apply(1, 4'h1, 0, 0, '1, 64'd0, 0, 32'hFFFF_FFFF, 16'd1, 64'h3000);
        apply(1, 4'h1, 0, 0, 64'h0000_0000_FFFF_FFFF, 64'd0, 0, 32'hFFFF_FFFF, 16'd1, 64'h3000);
        // R5: 32-bit class ignores upper bits, sign at bit 31
        apply(1, 4'h1, 1, 1, 64'h1_0000_0005, 64'd5, 0, 0, 16'd6, 64'h4000);
        apply(1, 4'h1, 0, 1, 64'h1_0000_0005, 64'd5, 0, 0, 16'd6, 64'h4000);
        apply(1, 4'hC, 1, 1, 64'h0000_0000_8000_0000, 64'd0, 0, 0, 16'd6, 64'h4000);
        apply(1, 4'hC, 0, 1, 64'h0000_0000_8000_0000, 64'd0, 0, 0, 16'd6, 64'h4000);
        // R3: bit test and equality variants
        apply(1, 4'h4, 0, 1, 64'hF0, 64'h0F, 0, 0, 16'd1, 64'h5000);
        apply(1, 4'h4, 0, 1, 64'h18, 64'h08, 0, 0, 16'd1, 64'h5000);
        apply(1, 4'h5, 0, 1, 64'h18, 64'h18, 0, 0, 16'd1, 64'h5000);
        // R1 / R2 equality edges
        apply(1, 4'h3, 0, 1, 64'd9, 64'd9, 0, 0, 16'd1, 64'h6000);
        apply(1, 4'hB, 0, 1, 64'd9, 64'd9, 0, 0, 16'd1, 64'h6000);
        apply(1, 4'h7, 0, 1, '1, '1, 0, 0, 16'd1, 64'h6000);
        apply(1, 4'hD, 0, 1, '1, '1, 0, 0, 16'd1, 64'h6000);
        // R9 call, R10 exit
        apply(1, 4'h8, 0, 0, 0, 0, 4'd3, 32'h0000_1234, 16'd0, 64'h7000);
        apply(1, 4'h9, 0, 0, 0, 0, 0, 0, 16'd0, 64'h7008);
        // R11 illegal encodings
        apply(1, 4'hE, 0, 0, 0, 0, 0, 0, 16'd5, 64'h8000);
        apply(1, 4'hF, 1, 1, 0, 0, 0, 0, 16'd5, 64'h8000);
        apply(1, 4'h0, 1, 0, 0, 0, 0, 0, 16'd5, 64'h8000);
        apply(1, 4'h8, 1, 0, 0, 0, 4'd2, 32'h55, 16'd5, 64'h8000);
        apply(1, 4'h9, 1, 0, 0, 0, 0, 0, 16'd5, 64'h8000);
        // R12: idle gaps
        apply(0, 4'h0, 0, 0, 0, 0, 0, 0, 16'd5, 64'h9000);
        apply(0, 4'h8, 0, 0, 0, 0, 0, 0, 16'd5, 64'h9000);

        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            bit [63:0] d, s;
            bit [31:0] im;
            d  = pick_val();
            s  = ($urandom_range(0, 4) == 0) ? d : pick_val();
            im = ($urandom_range(0, 4) == 0) ? d[31:0] : pick_val();
            apply($urandom_range(0, 9) != 0, 4'($urandom_range(0, 15)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  d, s, 4'($urandom_range(0, 15)), im,
                  16'($urandom()), {$urandom(), $urandom()});
        end

        @(negedge clk);
        check_pending();
        have_pend = 0;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule